// File: doc/BRIEF.md
# Errored Second Performance Monitor

This block grades a line's quality one second at a time. An external timebase sends a one-cycle pulse each second. Between two pulses the block counts errored events that arrive as single-cycle pulses on two groups of inputs. One group covers events seen at the local interface and the other covers events reported by the far end. Each group is masked by its own enable register.

When the second ends, the count for the interval is checked against two programmable limits: an 8-bit errored-second (ES) limit and a 16-bit severely-errored-second (SES) limit. The result increments a 16-bit ES counter, a 16-bit SES counter, or both. Any single enabled far-end event in the interval forces both increments. A zero limit can switch its monitor off, depending on two mode bits.

A plain register port sets the limits, the enables and the mode. The same port reads the two counters, and a read clears the counter it returns. The port has no back-pressure. A write takes effect at the next clock edge. A read request is answered exactly one cycle later with `rd_valid` high, and the block is always ready for another request.

Top module: `es_perf_monitor`

## Requirements
- R1: After reset, every register reads 0x0000 and no read data is valid until a request is made. The register addresses are: 0 mode, 1 ES limit, 2 SES limit high byte, 3 SES limit low byte, 4 local enable, 5 far-end enable, 6 ES counter, 7 SES counter.
- R2: Local enable bits map as follows: bit 3 slip, bit 2 AIS, bit 1 multiframe alignment loss, bit 0 frame alignment loss. Bits 7:4 always read 0. In any cycle, each asserted local input whose enable bit is 1 adds one to the interval count, and inputs whose enable bit is 0 add nothing.
- R3: When the ES limit is nonzero, an interval whose count is at or above the limit increments the ES counter, and an interval whose count is below it does not.
- R4: The SES limit is {high byte, low byte}. When it is nonzero, an interval whose count is at or above it increments the SES counter, and an interval whose count is below it does not.
- R5: When mode bit 6 is 1 and mode bit 7 is 0, a zero limit disables its monitor, and count-based increments from that monitor stop.
- R6: When a limit is zero and the disable condition of R5 does not hold, any interval with at least one counted event increments that counter, and an empty interval does not.
- R7: Far-end enable bits map as follows: 7 Sa6 code F, 6 Sa6 code E, 5 Sa6 code 8, 4 remote frame alarm, 3 slip, 2 AIS, 1 multiframe alignment loss, 0 frame alignment loss. One enabled far-end event in an interval increments both the ES and SES counters at that interval's end, whatever the limits are. Disabled far-end events have no effect.
- R8: An event that arrives in the same cycle as the second pulse belongs to the new interval.
- R9: The interval count saturates at 0xFFFF and restarts at each second pulse after the comparison.
- R10: The ES and SES counters saturate at 0xFFFF.
- R11: Reading a counter returns its value from before the read and clears it. An increment in the same cycle as the read leaves the counter at 1.
- R12: `rd_valid` is high in exactly the cycle after each `rd_req`, with `rd_data` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle pulse that ends an interval |
| loc_evt | input | 4 | Local event pulses (slip, AIS, multiframe loss, frame loss) |
| rem_evt | input | 8 | Far-end event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_req | input | 1 | Read request |
| rd_addr | input | 3 | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after request |
| rd_data | output | 16 | Read data |

## Verification
Local bursts are sent just below a limit, exactly at it and above it. This separates the at-or-above rule from the strictly-above rule, and it also tests the high byte of the SES limit. Masked inputs are sent alone to show that they add nothing. A single far-end pulse is sent with unreachable limits to show that it forces both increments. Zero limits are tried under each mode setting, with and without events, which separates the disable case from the any-event case. A pulse is sent together with the second pulse to show which interval it counts in. Long runs drive the interval count and the counters to their maximums, and one read is timed to coincide with an increment.

// File: rtl/epm_pkg.sv
package epm_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] A_ES_THR = 3'd1;
  localparam logic [ADDR_W-1:0] A_SES_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_SES_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_LOC_EN = 3'd4;
  localparam logic [ADDR_W-1:0] A_REM_EN = 3'd5;
  localparam logic [ADDR_W-1:0] A_ES_CNT = 3'd6;
  localparam logic [ADDR_W-1:0] A_SES_CNT = 3'd7;
  localparam int MODE_ZDIS_ON  = 6;
  localparam int MODE_ZDIS_OFF = 7;
endpackage

// File: rtl/epm_evt_accum.sv
module epm_evt_accum #(
  parameter int LOC_W = 4,
  parameter int REM_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [LOC_W-1:0] loc_evt,
  input  logic [LOC_W-1:0] loc_en,
  input  logic [REM_W-1:0] rem_evt,
  input  logic [REM_W-1:0] rem_en,
  output logic [CNT_W-1:0] evt_cnt,
  output logic             rem_hit
);
  localparam int ADD_W = $clog2(LOC_W + 1);

  logic [LOC_W-1:0] masked;
  logic [ADD_W-1:0] add;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] sat_sum;
  logic             rem_now;

  assign masked  = loc_evt & loc_en;
  assign rem_now = |(rem_evt & rem_en);

  always_comb begin
    add = '0;
    for (int i = 0; i < LOC_W; i++) begin
      add = add + ADD_W'(masked[i]);
    end
  end

  assign sum     = {1'b0, evt_cnt} + (CNT_W+1)'(add);
  assign sat_sum = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_cnt <= '0;
      rem_hit <= 1'b0;
    end else if (tick) begin
      evt_cnt <= CNT_W'(add);
      rem_hit <= rem_now;
    end else begin
      evt_cnt <= sat_sum;
      rem_hit <= rem_hit | rem_now;
    end
  end
endmodule

// File: rtl/epm_classify.sv
module epm_classify #(
  parameter int CNT_W = 16,
  parameter int THR_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [THR_W-1:0] thr,
  input  logic             zero_off,
  input  logic             forced,
  output logic             hit
);
  logic thr_zero;
  logic by_count;

  assign thr_zero = (thr == '0);

  always_comb begin
    if (thr_zero) by_count = !zero_off && (cnt != '0);
    else          by_count = (cnt >= CNT_W'(thr));
  end

  assign hit = forced | by_count;
endmodule

// File: rtl/epm_rc_counter.sv
module epm_rc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    value <= '0;
    else if (clr)                  value <= W'(inc);
    else if (inc && value != '1)   value <= value + 1'b1;
  end
endmodule

// File: rtl/es_perf_monitor.sv
module es_perf_monitor
  import epm_pkg::*;
#(
  parameter int LOC_W = 4,
  parameter int REM_W = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1s,
  input  logic [LOC_W-1:0]  loc_evt,
  input  logic [REM_W-1:0]  rem_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  rd_data
);
  logic [7:0]       mode_q;
  logic [7:0]       es_thr_q;
  logic [15:0]      ses_thr_q;
  logic [LOC_W-1:0] loc_en_q;
  logic [REM_W-1:0] rem_en_q;

  logic [CNT_W-1:0] evt_cnt;
  logic             rem_hit;
  logic             zero_off;
  logic             es_hit, ses_hit;
  logic             es_inc, ses_inc;
  logic             es_clr, ses_clr;
  logic [CNT_W-1:0] es_cnt, ses_cnt;
  logic [CNT_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '0;
      es_thr_q  <= '0;
      ses_thr_q <= '0;
      loc_en_q  <= '0;
      rem_en_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE:   mode_q          <= wr_data;
        A_ES_THR: es_thr_q        <= wr_data;
        A_SES_HI: ses_thr_q[15:8] <= wr_data;
        A_SES_LO: ses_thr_q[7:0]  <= wr_data;
        A_LOC_EN: loc_en_q        <= wr_data[LOC_W-1:0];
        A_REM_EN: rem_en_q        <= wr_data[REM_W-1:0];
        default: ;
      endcase
    end
  end

  epm_evt_accum #(.LOC_W(LOC_W), .REM_W(REM_W), .CNT_W(CNT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .tick(tick_1s),
    .loc_evt(loc_evt), .loc_en(loc_en_q),
    .rem_evt(rem_evt), .rem_en(rem_en_q),
    .evt_cnt(evt_cnt), .rem_hit(rem_hit)
  );

  assign zero_off = mode_q[MODE_ZDIS_ON] & ~mode_q[MODE_ZDIS_OFF];

  epm_classify #(.CNT_W(CNT_W), .THR_W(8)) u_es_cls (
    .cnt(evt_cnt), .thr(es_thr_q), .zero_off(zero_off),
    .forced(rem_hit), .hit(es_hit)
  );

  epm_classify #(.CNT_W(CNT_W), .THR_W(16)) u_ses_cls (
    .cnt(evt_cnt), .thr(ses_thr_q), .zero_off(zero_off),
    .forced(rem_hit), .hit(ses_hit)
  );

  assign es_inc  = tick_1s & es_hit;
  assign ses_inc = tick_1s & ses_hit;
  assign es_clr  = rd_req && (rd_addr == A_ES_CNT);
  assign ses_clr = rd_req && (rd_addr == A_SES_CNT);

  epm_rc_counter #(.W(CNT_W)) u_es_ctr (
    .clk(clk), .rst_n(rst_n), .inc(es_inc), .clr(es_clr), .value(es_cnt)
  );

  epm_rc_counter #(.W(CNT_W)) u_ses_ctr (
    .clk(clk), .rst_n(rst_n), .inc(ses_inc), .clr(ses_clr), .value(ses_cnt)
  );

  always_comb begin
    case (rd_addr)
      A_MODE:    rd_mux = CNT_W'(mode_q);
      A_ES_THR:  rd_mux = CNT_W'(es_thr_q);
      A_SES_HI:  rd_mux = CNT_W'(ses_thr_q[15:8]);
      A_SES_LO:  rd_mux = CNT_W'(ses_thr_q[7:0]);
      A_LOC_EN:  rd_mux = CNT_W'(loc_en_q);
      A_REM_EN:  rd_mux = CNT_W'(rem_en_q);
      A_ES_CNT:  rd_mux = es_cnt;
      default:   rd_mux = ses_cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/epm_checker.sv
module epm_checker
  import epm_pkg::*;
#(
  parameter int LOC_W = 4,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1s,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic              rem_hit,
  input logic              es_inc,
  input logic              ses_inc,
  input logic [CNT_W-1:0]  evt_cnt,
  input logic [CNT_W-1:0]  es_cnt,
  input logic [CNT_W-1:0]  ses_cnt
);
  logic es_rd, ses_rd;
  assign es_rd  = rd_req && (rd_addr == A_ES_CNT);
  assign ses_rd = rd_req && (rd_addr == A_SES_CNT);

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  a_r11_clear_es: assert property (@(posedge clk) disable iff (!rst_n)
    (es_rd && !es_inc) |=> (es_cnt == '0));
  a_r11_keep_es: assert property (@(posedge clk) disable iff (!rst_n)
    (es_rd && es_inc) |=> (es_cnt == CNT_W'(1)));
  a_r10_es_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !es_rd |=> (es_cnt >= $past(es_cnt)));
  a_r10_ses_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !ses_rd |=> (ses_cnt >= $past(ses_cnt)));
  a_r7_forced_both: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && rem_hit) |-> (es_inc && ses_inc));
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1s |=> (evt_cnt <= CNT_W'(LOC_W)));
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_1s |=> (evt_cnt >= $past(evt_cnt)));
endmodule

bind es_perf_monitor epm_checker #(.LOC_W(LOC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .rd_req(rd_req),
  .rd_addr(rd_addr), .rd_valid(rd_valid), .rem_hit(rem_hit),
  .es_inc(es_inc), .ses_inc(ses_inc), .evt_cnt(evt_cnt),
  .es_cnt(es_cnt), .ses_cnt(ses_cnt)
);

// File: tb/tb_es_perf_monitor.sv
module tb_es_perf_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1s = 1'b0;
  logic [3:0]  loc_evt = '0;
  logic [7:0]  rem_evt = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_req = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic        rd_valid;
  logic [15:0] rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] e_val;
  string       e_tag;

  always #4 clk = ~clk;

  es_perf_monitor dut (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .loc_evt(loc_evt),
    .rem_evt(rem_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    rd_req = 1'b1; rd_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b1) begin
      fails++;
      $display("FAIL R12: rd_valid=%b expected 1", rd_valid);
    end
    rd_req = 1'b0;
  endtask

  task automatic tk();
    tick_1s = 1'b1;
    @(negedge clk);
    tick_1s = 1'b0;
  endtask

  task automatic ev(input logic [3:0] b);
    loc_evt = b;
    @(negedge clk);
    loc_evt = '0;
  endtask

  task automatic rev(input logic [7:0] b);
    rem_evt = b;
    @(negedge clk);
    rem_evt = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12: unexpected rd_valid, data=%h expected none", rd_data);
      end else begin
        e_val = exp_q.pop_front();
        e_tag = tag_q.pop_front();
        checks++;
        if (rd_data !== e_val) begin
          fails++;
          $display("FAIL %s: rd_data=%h expected %h", e_tag, rd_data, e_val);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0) begin
      fails++; $display("FAIL R1: rd_valid=%b expected 0", rd_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) rd(3'(a), 16'h0000, "R1");

    // R2 mask readback and threshold setup
    wr(3'd4, 8'hFF);
    rd(3'd4, 16'h000F, "R2");
    wr(3'd1, 8'd3);
    wr(3'd3, 8'd5);
    tk();
    // R3 below limit
    ev(4'h8); ev(4'h8); tk();
    rd(3'd6, 16'd0, "R3");
    // R3 at limit, R4 below
    ev(4'h8); ev(4'h8); ev(4'h8); tk();
    rd(3'd6, 16'd1, "R3");
    rd(3'd7, 16'd0, "R4");
    // R4 at limit (5 events)
    ev(4'hF); ev(4'h1); tk();
    rd(3'd6, 16'd1, "R3");
    rd(3'd7, 16'd1, "R4");
    // R4 high byte: limit 0x0105
    wr(3'd2, 8'h01);
    rd(3'd2, 16'h0001, "R4");
    ev(4'hF); ev(4'h1); tk();
    rd(3'd6, 16'd1, "R3");
    rd(3'd7, 16'd0, "R4");

    // R2 masked events add nothing
    wr(3'd4, 8'h01);
    for (int i = 0; i < 5; i++) ev(4'hE);
    tk();
    rd(3'd6, 16'd0, "R2");
    ev(4'h1); ev(4'h1); ev(4'h1); tk();
    rd(3'd6, 16'd1, "R2");

    // R8 event with the second pulse goes to the new interval
    wr(3'd4, 8'h0F);
    wr(3'd1, 8'd1);
    tk();
    loc_evt = 4'h1; tick_1s = 1'b1;
    @(negedge clk);
    loc_evt = '0; tick_1s = 1'b0;
    rd(3'd6, 16'd0, "R8");
    tk();
    rd(3'd6, 16'd1, "R8");

    // R5 / R6 zero limits
    wr(3'd1, 8'd0);
    wr(3'd0, 8'h40);
    ev(4'h1); tk();
    rd(3'd6, 16'd0, "R5");
    wr(3'd0, 8'hC0);
    ev(4'h1); tk();
    rd(3'd6, 16'd1, "R6");
    tk();
    rd(3'd6, 16'd0, "R6");
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'h40);
    ev(4'h2); tk();
    rd(3'd7, 16'd0, "R5");
    wr(3'd0, 8'h00);
    ev(4'h2); tk();
    rd(3'd7, 16'd1, "R6");
    rd(3'd6, 16'd1, "R6");

    // R7 far-end events force both
    wr(3'd1, 8'd200);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd5, 8'h10);
    rd(3'd5, 16'h0010, "R7");
    rev(8'h10); tk();
    rd(3'd6, 16'd1, "R7");
    rd(3'd7, 16'd1, "R7");
    rev(8'h01); tk();
    rd(3'd6, 16'd0, "R7");
    rd(3'd7, 16'd0, "R7");

    // R11 read coinciding with increment
    rev(8'h10);
    tick_1s = 1'b1;
    rd(3'd6, 16'd0, "R11");
    tick_1s = 1'b0;
    rd(3'd6, 16'd1, "R11");
    rd(3'd7, 16'd1, "R11");

    // R9 saturating interval count against limit 0xFFFF
    wr(3'd5, 8'h00);
    wr(3'd1, 8'd0);
    tk();
    loc_evt = 4'hF;
    repeat (16383) @(negedge clk);
    loc_evt = '0;
    tk();
    rd(3'd7, 16'd0, "R9");
    rd(3'd6, 16'd1, "R9");
    loc_evt = 4'hF;
    repeat (16400) @(negedge clk);
    loc_evt = '0;
    tk();
    rd(3'd7, 16'd1, "R9");
    rd(3'd6, 16'd1, "R9");

    // R10 counters saturate
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h01);
    rem_evt = 8'h01; tick_1s = 1'b1;
    repeat (65540) @(negedge clk);
    rem_evt = '0; tick_1s = 1'b0;
    rd(3'd6, 16'hFFFF, "R10");
    rd(3'd7, 16'hFFFF, "R10");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R12: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule